// File: doc/BRIEF.md
# Load Extend and Condition Unit

This stage sits after the memory read port of a 32-bit register machine whose bits are numbered big-endian. Bit 0 is the most significant bit of a word and bit 31 is the least significant. Each valid cycle it receives one of four decoded load kinds: immediate, byte, halfword or word. It also receives the 20-bit immediate field, the addressed memory word, the two low effective-address bits and an indirect-addressing flag. It forms the 32-bit value bound for destination register R and a two-bit condition-code update.

An immediate load that is marked indirect is an illegal encoding. In that case the stage signals a trap with a fixed vector instead of producing a result, and it suppresses both the register write and the condition write. All outputs are registered and appear one clock after the strobe.

Top module: `ldx_unit`

## Requirements
- R1: While rst_ni is low, every output is zero.
- R2: Outputs follow a valid_i strobe by exactly one clock edge. After an edge where valid_i was low, reg_we_o, cc_we_o and trap_o are 0. Whenever no register write is made, reg_wdata_o, cc_o and trap_vec_o are 0, except that trap_vec_o carries the vector during a trap.
- R3: op_i = 0 is the immediate load. The result is imm_i sign-extended from bit 19 (instruction bit 12) to 32 bits.
- R4: op_i = 1 is the byte load. ea_lo_i selects a byte of mem_word_i: 0 selects bits [31:24], 1 selects [23:16], 2 selects [15:8] and 3 selects [7:0]. The byte is placed in reg_wdata_o[7:0] and the upper 24 bits are zero.
- R5: op_i = 2 is the halfword load. ea_lo_i[1] = 0 selects mem_word_i[31:16] and 1 selects [15:0]. The halfword is sign-extended to 32 bits.
- R6: op_i = 3 is the word load. mem_word_i is written unchanged.
- R7: For immediate, halfword and word loads, cc_o reports the sign of the result. A zero result gives 2'b00, a result with reg_wdata_o[31] set gives 2'b01, and any other result gives 2'b10.
- R8: For a byte load, cc_o is 2'b00 for a zero byte and 2'b10 otherwise. It is never 2'b01.
- R9: An immediate load with indirect_i = 1 sets trap_o, drives trap_vec_o = 8'h40, and keeps reg_we_o and cc_we_o at 0.
- R10: indirect_i has no effect on byte, halfword or word loads.
- R11: reg_we_o and cc_we_o are always equal, and neither is set together with trap_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Load strobe |
| op_i | input | 2 | Load kind: 0 immediate, 1 byte, 2 halfword, 3 word |
| imm_i | input | 20 | Instruction value field, bits 12–31 |
| mem_word_i | input | 32 | Addressed memory word |
| ea_lo_i | input | 2 | Low effective-address bits |
| indirect_i | input | 1 | Indirect addressing flag |
| reg_we_o | output | 1 | Register R write enable |
| reg_wdata_o | output | 32 | Register R write data |
| cc_we_o | output | 1 | Condition write enable |
| cc_o | output | 2 | Condition value {CC3, CC4} |
| trap_o | output | 1 | Nonexistent-instruction trap |
| trap_vec_o | output | 8 | Trap vector |

## Verification
Directed patterns come first. They walk a distinctive word through all four byte lanes and both halfword positions, which tells a lane or half swap apart from a correct select. They also put 0x00, 0x7F and 0x80-type values into each width, which separates sign extension from zero fill and exposes a byte load that reports negative. Immediate values at zero, the largest positive value and the most negative value probe the extension from bit 19. Indirect flags on every op separate the single trapping case from the three load kinds that must ignore the flag. A long pseudo-random stretch, with valid_i dropping at random, then checks the one-cycle timing and the idle outputs against the bench model on every clock.

// File: rtl/ldx_pkg.sv
package ldx_pkg;
  typedef enum logic [1:0] {
    OP_IMM  = 2'd0,
    OP_BYTE = 2'd1,
    OP_HALF = 2'd2,
    OP_WORD = 2'd3
  } ld_op_e;

  localparam logic [1:0] CC_ZERO = 2'b00;
  localparam logic [1:0] CC_NEG  = 2'b01;
  localparam logic [1:0] CC_POS  = 2'b10;
endpackage

// File: rtl/ldx_extract.sv
module ldx_extract #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 20,
  parameter int BYTE_W = 8
) (
  input  ldx_pkg::ld_op_e   op_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [XLEN-1:0]   word_i,
  input  logic [1:0]        ea_lo_i,
  output logic [XLEN-1:0]   value_o
);
  import ldx_pkg::*;

  localparam int HALF_W = 2 * BYTE_W;
  localparam int NLANE  = XLEN / BYTE_W;
  localparam int NHALF  = XLEN / HALF_W;

  logic [NLANE-1:0][BYTE_W-1:0] lane;
  logic [NHALF-1:0][HALF_W-1:0] half;

  // index 0 is the most significant lane (big-endian numbering)
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane[g] = word_i[XLEN-1-g*BYTE_W -: BYTE_W];
  end
  for (genvar g = 0; g < NHALF; g++) begin : g_half
    assign half[g] = word_i[XLEN-1-g*HALF_W -: HALF_W];
  end

  logic [BYTE_W-1:0] sel_byte;
  logic [HALF_W-1:0] sel_half;
  assign sel_byte = lane[ea_lo_i];
  assign sel_half = half[ea_lo_i[1]];

  always_comb begin
    unique case (op_i)
      OP_IMM:  value_o = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
      OP_BYTE: value_o = {{(XLEN-BYTE_W){1'b0}}, sel_byte};
      OP_HALF: value_o = {{(XLEN-HALF_W){sel_half[HALF_W-1]}}, sel_half};
      default: value_o = word_i;
    endcase
  end
endmodule

// File: rtl/ldx_cond.sv
module ldx_cond #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] value_i,
  input  logic            unsigned_i,
  output logic [1:0]      cc_o
);
  import ldx_pkg::*;

  logic is_zero;
  assign is_zero = (value_i == '0);

  always_comb begin
    if (is_zero)                            cc_o = CC_ZERO;
    else if (!unsigned_i && value_i[XLEN-1]) cc_o = CC_NEG;
    else                                    cc_o = CC_POS;
  end
endmodule

// File: rtl/ldx_decode.sv
module ldx_decode (
  input  logic            valid_i,
  input  ldx_pkg::ld_op_e op_i,
  input  logic            indirect_i,
  output logic            write_o,
  output logic            trap_o,
  output logic            unsigned_o
);
  import ldx_pkg::*;

  logic illegal;
  assign illegal    = (op_i == OP_IMM) && indirect_i;
  assign trap_o     = valid_i && illegal;
  assign write_o    = valid_i && !illegal;
  assign unsigned_o = (op_i == OP_BYTE);
endmodule

// File: rtl/ldx_unit.sv
module ldx_unit #(
  parameter int              XLEN     = 32,
  parameter int              IMM_W    = 20,
  parameter int              VEC_W    = 8,
  parameter logic [VEC_W-1:0] TRAP_VEC = 8'h40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [XLEN-1:0]  mem_word_i,
  input  logic [1:0]       ea_lo_i,
  input  logic             indirect_i,
  output logic             reg_we_o,
  output logic [XLEN-1:0]  reg_wdata_o,
  output logic             cc_we_o,
  output logic [1:0]       cc_o,
  output logic             trap_o,
  output logic [VEC_W-1:0] trap_vec_o
);
  import ldx_pkg::*;

  ld_op_e          op;
  logic [XLEN-1:0] value;
  logic [1:0]      cc;
  logic            wr, trp, uns;

  assign op = ld_op_e'(op_i);

  ldx_decode u_dec (
    .valid_i   (valid_i),
    .op_i      (op),
    .indirect_i(indirect_i),
    .write_o   (wr),
    .trap_o    (trp),
    .unsigned_o(uns)
  );

  ldx_extract #(.XLEN(XLEN), .IMM_W(IMM_W)) u_ext (
    .op_i   (op),
    .imm_i  (imm_i),
    .word_i (mem_word_i),
    .ea_lo_i(ea_lo_i),
    .value_o(value)
  );

  ldx_cond #(.XLEN(XLEN)) u_cc (
    .value_i   (value),
    .unsigned_i(uns),
    .cc_o      (cc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_we_o    <= 1'b0;
      reg_wdata_o <= '0;
      cc_we_o     <= 1'b0;
      cc_o        <= CC_ZERO;
      trap_o      <= 1'b0;
      trap_vec_o  <= '0;
    end else begin
      reg_we_o    <= wr;
      cc_we_o     <= wr;
      reg_wdata_o <= wr ? value : '0;
      cc_o        <= wr ? cc : CC_ZERO;
      trap_o      <= trp;
      trap_vec_o  <= trp ? TRAP_VEC : '0;
    end
  end
endmodule

// File: rtl/ldx_unit_chk.sv
module ldx_unit_chk #(
  parameter int XLEN = 32,
  parameter int VEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [1:0]       op_i,
  input logic             indirect_i,
  input logic             reg_we_o,
  input logic [XLEN-1:0]  reg_wdata_o,
  input logic             cc_we_o,
  input logic [1:0]       cc_o,
  input logic             trap_o,
  input logic [VEC_W-1:0] trap_vec_o
);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !reg_we_o && !cc_we_o && !trap_o);

  assert_byte_zero_fill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'd1 |=> reg_wdata_o[XLEN-1:8] == '0);

  assert_neg_has_sign_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o && cc_o == 2'b01 |-> reg_wdata_o[XLEN-1]);

  assert_byte_never_neg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'd1 |=> cc_o != 2'b01);

  assert_illegal_traps_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'd0 && indirect_i |=>
      trap_o && trap_vec_o == 8'h40 && !reg_we_o && !cc_we_o);

  assert_legal_writes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i != 2'd0 |=> reg_we_o && !trap_o);

  assert_enables_tied_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o == cc_we_o && !(trap_o && reg_we_o));
endmodule

bind ldx_unit ldx_unit_chk #(.XLEN(XLEN), .VEC_W(VEC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .op_i       (op_i),
  .indirect_i (indirect_i),
  .reg_we_o   (reg_we_o),
  .reg_wdata_o(reg_wdata_o),
  .cc_we_o    (cc_we_o),
  .cc_o       (cc_o),
  .trap_o     (trap_o),
  .trap_vec_o (trap_vec_o)
);

// File: tb/sim_ldx_unit.sv
module sim_ldx_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [19:0] imm_i = '0;
  logic [31:0] mem_word_i = '0;
  logic [1:0]  ea_lo_i = '0;
  logic        indirect_i = 1'b0;
  logic        reg_we_o, cc_we_o, trap_o;
  logic [31:0] reg_wdata_o;
  logic [1:0]  cc_o;
  logic [7:0]  trap_vec_o;

  int checks = 0, errors = 0;
  bit have_exp = 0;
  logic        e_we, e_trap;
  logic [31:0] e_data;
  logic [1:0]  e_cc;
  logic [7:0]  e_vec;
  string       e_tag, e_cctag;

  always #2.5 clk_i = ~clk_i;

  ldx_unit u0 (.*);

  function automatic logic [31:0] model_val(int op, logic [19:0] imm, logic [31:0] w, logic [1:0] ea);
    int t;
    logic [15:0] h;
    case (op)
      0: begin t = int'({imm, 12'h000}); return 32'(t >>> 12); end
      1: return (w >> (8 * (3 - int'(ea)))) & 32'hff;
      2: begin h = 16'(w >> (16 * (1 - int'(ea[1])))); return 32'(int'(shortint'(h))); end
      default: return w;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    if (!have_exp) return;
    chk("R2 reg_we", 32'(reg_we_o), 32'(e_we));
    chk("R11 cc_we", 32'(cc_we_o), 32'(e_we));
    chk("R9 trap", 32'(trap_o), 32'(e_trap));
    chk("R9 trap_vec", 32'(trap_vec_o), 32'(e_vec));
    chk(e_tag, reg_wdata_o, e_data);
    chk(e_cctag, 32'(cc_o), 32'(e_cc));
  endtask

  task automatic step(bit v, int op, logic [19:0] imm, logic [31:0] w, logic [1:0] ea, bit ind);
    logic [31:0] val;
    @(negedge clk_i);
    compare();
    valid_i = v; op_i = 2'(op); imm_i = imm; mem_word_i = w; ea_lo_i = ea; indirect_i = ind;
    val = model_val(op, imm, w, ea);
    e_trap = v && op == 0 && ind;
    e_we = v && !e_trap;
    e_vec = e_trap ? 8'h40 : 8'h00;
    e_data = e_we ? val : 32'h0;
    if (!e_we) e_cc = 2'b00;
    else if (val == 0) e_cc = 2'b00;
    else if (op != 1 && val[31]) e_cc = 2'b01;
    else e_cc = 2'b10;
    case (op)
      0: e_tag = "R3 imm data";
      1: e_tag = ind ? "R10 byte data" : "R4 byte data";
      2: e_tag = ind ? "R10 half data" : "R5 half data";
      default: e_tag = ind ? "R10 word data" : "R6 word data";
    endcase
    if (!v) e_tag = "R2 idle data";
    e_cctag = (op == 1) ? "R8 cc" : "R7 cc";
    have_exp = 1;
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk_i);
    chk("R1 reset we", 32'(reg_we_o), 0);
    chk("R1 reset data", reg_wdata_o, 0);
    chk("R1 reset trap", 32'({trap_o, cc_we_o, cc_o, trap_vec_o}), 0);
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) step(1, 1, '0, 32'h80_7F_00_C3, 2'(i), 0);
    for (int i = 0; i < 4; i++) step(1, 2, '0, 32'h8001_7FFF, 2'(i), 0);
    step(1, 2, '0, 32'h0000_1234, 2'd0, 0);
    step(1, 0, 20'h00000, '0, 2'd0, 0);
    step(1, 0, 20'h7FFFF, '0, 2'd0, 0);
    step(1, 0, 20'h80000, '0, 2'd0, 0);
    step(1, 0, 20'h00001, '0, 2'd0, 0);
    step(1, 3, '0, 32'h0, 2'd1, 0);
    step(1, 3, '0, 32'hFFFF_FFFF, 2'd2, 0);
    step(1, 3, '0, 32'h1234_5678, 2'd3, 0);
    step(1, 0, 20'h80000, 32'hFFFF_FFFF, 2'd0, 1);
    step(0, 3, '0, 32'h5555_5555, 2'd0, 0);
    step(1, 0, 20'h00003, '0, 2'd0, 1);
    step(1, 1, '0, 32'hFF00_0000, 2'd0, 1);
    step(1, 2, '0, 32'h0000_8000, 2'd3, 1);
    step(1, 3, '0, 32'h8000_0000, 2'd0, 1);
    for (int i = 0; i < 2000; i++)
      step(($urandom % 4) != 0, int'($urandom % 4), 20'($urandom), $urandom, 2'($urandom),
           ($urandom % 3) == 0);
    step(0, 0, '0, '0, 2'd0, 0);
    @(negedge clk_i);
    compare();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule